// File: doc/BRIEF.md
# GPIO Event Latch and Interrupt Combiner

This block watches a word of per-pin input data and records pin events in a sticky status word. It drives one interrupt line that is high whenever any recorded event is also enabled. The input data word comes from pin resolution logic elsewhere. That logic also supplies a mask, valid for the current cycle, of the bits whose input value has just changed. Register decoding is also done elsewhere and delivers a shared write-data word with single-cycle strobes.

Each pin has two configuration bits. With the type bit low, the pin is level sensitive: its status bit is set in every cycle in which its input is high. With the type bit high and the both-edge bit high, the pin records any reported change. With the type bit high and the both-edge bit low, it records only a reported change to high. Software clears status bits by writing ones to them. The enable word can be loaded outright, or have bits set or cleared through two alias strobes.

Top module: `gpio_evt_irq`

## Requirements
- R1: When evt_type_i[n]=0, status_o[n] is 1 after any clock edge at which din_i[n] was 1.
- R2: When evt_type_i[n]=1 and both_edge_i[n]=1, status_o[n] is set after an edge at which din_chg_i[n]=1, whatever the value of din_i[n].
- R3: When evt_type_i[n]=1 and both_edge_i[n]=0, status_o[n] is set only after an edge at which din_chg_i[n]=1 and din_i[n]=1. A reported change to low is ignored.
- R4: Status bits are sticky. When st_clr_i=1, every status bit whose wr_data_i bit is 1 is cleared. Other bits are kept.
- R5: irq_o is a register. After each edge it equals the OR of (status_o AND enable_o) as they stand after that same edge. It does not change between edges.
- R6: At an edge, en_wr_i=1 loads wr_data_i into enable_o. en_set_i=1 ORs wr_data_i into enable_o. en_clr_i=1 clears the enable bits where wr_data_i is 1.
- R7: Changes to evt_type_i or both_edge_i with din_chg_i=0 never set an edge-type status bit. A bit that becomes level-type with its input high is set at the next edge.
- R8: If a status clear and a new event hit the same bit in one cycle, the bit stays set. A level bit cleared while its input is still high is therefore set again.
- R9: Reset (rst_n=0, asynchronous) forces status_o, enable_o and irq_o to 0.
- R10: When several enable strobes are active in one cycle, they are applied in this order: load, then set, then clear. A bit both set and cleared ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | WIDTH | Current input data word |
| din_chg_i | input | WIDTH | Bits of din_i that changed this cycle |
| evt_type_i | input | WIDTH | Per-pin type: 0 level, 1 edge |
| both_edge_i | input | WIDTH | Per-pin edge select: 1 both edges, 0 rising only |
| wr_data_i | input | WIDTH | Shared write data for the strobes |
| en_wr_i | input | 1 | Load enable word from wr_data_i |
| en_set_i | input | 1 | OR wr_data_i into enable word |
| en_clr_i | input | 1 | Clear enable bits set in wr_data_i |
| st_clr_i | input | 1 | Clear status bits set in wr_data_i |
| status_o | output | WIDTH | Sticky event status |
| enable_o | output | WIDTH | Event enable word |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench targets four failure modes. A reported change to low on a rising-only pin is checked, since a design that ignored the type split would latch the falling change. Same-cycle clear and event are checked, since a design that lets the clear win would drop a still-high level input. A set and a clear of the same enable bit are applied together, so reversed strobe ordering would leave that bit on. Configuration-only changes with no change mask are checked, since edge logic that compared the configuration would raise spurious status bits. The interrupt is also sampled between the driving of a new level and the next edge, so a combinational interrupt path would show up early.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Write strobes delivered by the register decoder, one cycle wide.
    typedef struct packed {
        logic en_wr;
        logic en_set;
        logic en_clr;
        logic st_clr;
    } wr_strobe_t;

endpackage

// File: rtl/evt_detect.sv
module evt_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] chg_i,
    input  logic [WIDTH-1:0] typ_i,
    input  logic [WIDTH-1:0] both_i,
    output logic [WIDTH-1:0] hit_o
);

    // Per pin: level mode passes the data bit; edge mode requires a
    // reported change, qualified by the new value unless both edges count.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
        logic edge_hit;
        assign edge_hit  = chg_i[gi] & (both_i[gi] | din_i[gi]);
        assign hit_o[gi] = typ_i[gi] ? edge_hit : din_i[gi];
    end

endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  wr_strobe_t       stb_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] typ_i,
    input  logic [WIDTH-1:0] chg_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [WIDTH-1:0] st;
        logic [WIDTH-1:0] en;
        logic             irq;
    } state_t;

    state_t s_d, s_q;
    logic [WIDTH-1:0] clr_mask_d;

    always_comb begin
        s_d = s_q;
        // enable: load, then set, then clear
        if (stb_i.en_wr)  s_d.en = wdata_i;
        if (stb_i.en_set) s_d.en = s_d.en | wdata_i;
        if (stb_i.en_clr) s_d.en = s_d.en & ~wdata_i;
        // status: clear first, new events override
        clr_mask_d = stb_i.st_clr ? wdata_i : '0;
        s_d.st     = (s_q.st & ~clr_mask_d) | hit_i;
        s_d.irq    = |(s_d.st & s_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.st;
    assign enable_o = s_q.en;
    assign irq_o    = s_q.irq;

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(din_i & ~typ_i)) == $past(din_i & ~typ_i))); // R1

    AST_NO_CFG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_i == '0) && ((din_i & ~typ_i) == '0)) |=> ((status_o & ~$past(status_o)) == '0)); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i.st_clr |=> ((status_o & $past(status_o)) == $past(status_o))); // R4

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.en_set && !stb_i.en_clr) |=> ((enable_o & $past(wdata_i)) == $past(wdata_i))); // R6

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i.en_clr |=> ((enable_o & $past(wdata_i)) == '0)); // R10

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_o & enable_o)); // R5

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] din_chg_i,
    input  logic [WIDTH-1:0] evt_type_i,
    input  logic [WIDTH-1:0] both_edge_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             en_wr_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             st_clr_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o,
    output logic             irq_o
);

    logic [WIDTH-1:0] hit;
    wr_strobe_t       stb;

    assign stb = '{en_wr: en_wr_i, en_set: en_set_i, en_clr: en_clr_i, st_clr: st_clr_i};

    evt_detect #(.WIDTH(WIDTH)) i_detect (
        .din_i  (din_i),
        .chg_i  (din_chg_i),
        .typ_i  (evt_type_i),
        .both_i (both_edge_i),
        .hit_o  (hit)
    );

    evt_regs #(.WIDTH(WIDTH)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .wdata_i  (wr_data_i),
        .stb_i    (stb),
        .din_i    (din_i),
        .typ_i    (evt_type_i),
        .chg_i    (din_chg_i),
        .status_o (status_o),
        .enable_o (enable_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/test_gpio_evt_irq.sv
module test_gpio_evt_irq;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0, chg = '0, typ = '0, both = '0, wdata = '0;
    logic         en_wr = 1'b0, en_set = 1'b0, en_clr = 1'b0, st_clr = 1'b0;
    logic [W-1:0] status, enable;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    gpio_evt_irq #(.WIDTH(W)) i_gpio_evt_irq (
        .clk(clk), .rst_n(rst_n), .din_i(din), .din_chg_i(chg),
        .evt_type_i(typ), .both_edge_i(both), .wr_data_i(wdata),
        .en_wr_i(en_wr), .en_set_i(en_set), .en_clr_i(en_clr), .st_clr_i(st_clr),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    // strobe field: {en_wr, en_set, en_clr, st_clr}
    typedef struct packed {
        logic [W-1:0] din;
        logic [W-1:0] chg;
        logic [W-1:0] typ;
        logic [W-1:0] both;
        logic [W-1:0] wdata;
        logic [3:0]   stb;
        logic [W-1:0] exp_st;
        logic [W-1:0] exp_en;
        logic         exp_irq;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h1,        4'b1000, 32'h0, 32'h1, 1'b0, 8'd6},  // R6 load
        '{32'h1, 32'h1, 32'h0, 32'h0, 32'h0,        4'b0000, 32'h1, 32'h1, 1'b1, 8'd1},  // R1 level
        '{32'h0, 32'h1, 32'h0, 32'h0, 32'h0,        4'b0000, 32'h1, 32'h1, 1'b1, 8'd4},  // R4 sticky
        '{32'h0, 32'h0, 32'h0, 32'h0, 32'h1,        4'b0001, 32'h0, 32'h1, 1'b0, 8'd4},  // R4 clear
        '{32'h2, 32'h2, 32'h2, 32'h0, 32'h0,        4'b0000, 32'h2, 32'h1, 1'b0, 8'd3},  // R3 rise
        '{32'h2, 32'h0, 32'h2, 32'h0, 32'h2,        4'b0100, 32'h2, 32'h3, 1'b1, 8'd6},  // R6 set
        '{32'h2, 32'h0, 32'h2, 32'h0, 32'h2,        4'b0001, 32'h0, 32'h3, 1'b0, 8'd3},  // R3 no re-set
        '{32'h0, 32'h2, 32'h2, 32'h0, 32'h0,        4'b0000, 32'h0, 32'h3, 1'b0, 8'd3},  // R3 fall ignored
        '{32'h4, 32'h4, 32'h6, 32'h4, 32'h0,        4'b0000, 32'h4, 32'h3, 1'b0, 8'd2},  // R2 rise
        '{32'h4, 32'h0, 32'h6, 32'h4, 32'h4,        4'b0001, 32'h0, 32'h3, 1'b0, 8'd2},  // R2 clear
        '{32'h0, 32'h4, 32'h6, 32'h4, 32'h0,        4'b0000, 32'h4, 32'h3, 1'b0, 8'd2},  // R2 fall
        '{32'h0, 32'h0, 32'h6, 32'h4, 32'h1,        4'b0010, 32'h4, 32'h2, 1'b0, 8'd6},  // R6 clear
        '{32'h0, 32'h0, 32'h6, 32'h4, 32'h4,        4'b1000, 32'h4, 32'h4, 1'b1, 8'd5},  // R5 irq
        '{32'h2, 32'h0, 32'h6, 32'h6, 32'hFFFFFFFF, 4'b0001, 32'h0, 32'h4, 1'b0, 8'd7},  // R7 no edge
        '{32'h2, 32'h0, 32'h4, 32'h4, 32'h0,        4'b0000, 32'h2, 32'h4, 1'b0, 8'd7},  // R7 to level
        '{32'h2, 32'h0, 32'h4, 32'h4, 32'h2,        4'b0001, 32'h2, 32'h4, 1'b0, 8'd8},  // R8 event wins
        '{32'h2, 32'h0, 32'h4, 32'h4, 32'h2,        4'b0100, 32'h2, 32'h6, 1'b1, 8'd6},  // R6 set
        '{32'h2, 32'h0, 32'h4, 32'h4, 32'h4,        4'b0110, 32'h2, 32'h2, 1'b1, 8'd10}  // R10 order
    };

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        chg = '0; wdata = '0;
        en_wr = 1'b0; en_set = 1'b0; en_clr = 1'b0; st_clr = 1'b0;
    endtask

    initial begin
        // R9: reset state
        #5;
        check(status, '0, 9, "status in reset");
        check(enable, '0, 9, "enable in reset");
        check({31'b0, irq}, '0, 9, "irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            din = VECS[i].din; chg = VECS[i].chg; typ = VECS[i].typ;
            both = VECS[i].both; wdata = VECS[i].wdata;
            {en_wr, en_set, en_clr, st_clr} = VECS[i].stb;
            @(posedge clk);
            @(negedge clk);
            check(status, VECS[i].exp_st, int'(VECS[i].req), $sformatf("vec %0d status", i));
            check(enable, VECS[i].exp_en, int'(VECS[i].req), $sformatf("vec %0d enable", i));
            check({31'b0, irq}, {31'b0, VECS[i].exp_irq}, int'(VECS[i].req),
                  $sformatf("vec %0d irq", i));
        end
        idle();

        // R5: irq is registered; a new level shows only after the edge
        typ = '0; both = '0; din = '0;
        wdata = 32'h1; st_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        idle();
        wdata = 32'h8; en_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        idle();
        check({31'b0, irq}, '0, 5, "irq idle before level");
        din = 32'h8; chg = 32'h8;
        #2;
        check({31'b0, irq}, '0, 5, "irq before edge");
        @(posedge clk); @(negedge clk);
        chg = '0;
        check({31'b0, irq}, 32'h1, 5, "irq after edge");
        check(status, 32'hA, 1, "level bit3 set");

        // R8: level bit cleared while still high sets again
        wdata = 32'h8; st_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        idle();
        check(status, 32'hA, 8, "level bit re-set");

        // R9: mid-run reset
        rst_n = 1'b0;
        #2;
        check(status, '0, 9, "status after mid reset");
        check(enable, '0, 9, "enable after mid reset");
        check({31'b0, irq}, '0, 9, "irq after mid reset");
        din = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule